// File: doc/BRIEF.md
# Per-Warp Register Scoreboard

This block sits between decode and an in-order issue stage and keeps several warps free of read-after-write and write-after-write hazards. Each warp owns a small pool of slots. Every slot holds one destination register of an instruction that has issued but not yet written back. A warp with a full pool therefore cannot issue another instruction that writes a register. Each warp also has one instruction-buffer entry. When an instruction is decoded into that entry, its two source registers and its destination register are compared against the warp's live slots. The matching slots are recorded as a dependency vector that stays with the entry.

When a writeback arrives, the slot it names is freed. The matching bit is cleared in that warp's buffered entry. An entry becomes ready once its vector is all zero. The issue scheduler picks only among ready entries. At issue, the entry's destination claims the lowest-numbered free slot. That slot number appears on `iss_slot` in the same cycle, and the pipeline carries it to writeback.

Same-cycle events on one warp resolve as follows. A writeback in the same cycle as a decode is bypassed, so the freed slot sets no dependency bit. An issue in the same cycle as a decode is also forwarded, so the newly reserved slot is included in the lookup. Operand reads and the register file itself are outside this block.

Top module: `warp_scoreboard`

## Requirements
- R1: While reset is asserted and immediately after it is released, every entry is invalid, no slot is reserved, and `ready` and `entry_valid` are all zero.
- R2: An instruction decoded into a warp whose live slots match none of its registers shows `entry_valid` and `ready` high for that warp from the cycle after decode.
- R3: If either source register equals the register of a live slot of the same warp, the entry is not ready (read-after-write).
- R4: If the instruction writes a register (`dec_wr_en` = 1) whose number equals the register of a live slot of the same warp, the entry is not ready (write-after-write).
- R5: An issue (`iss_valid`) of a register-writing entry reserves the lowest-numbered free slot of that warp, reported on `iss_slot` in the same cycle. Slot numbers run from 0 to SLOTS-1. From the next cycle the entry is invalid and `ready` is low for that warp.
- R6: A writeback (`wb_valid`, `wb_warp`, `wb_slot`) frees that slot and clears its dependency bit in that warp's entry. An entry with several dependencies stays not ready until the last of them is cleared.
- R7: When all SLOTS slots of a warp are reserved, an entry that writes a register is held not ready until a slot frees. An entry that writes no register is not held by this condition.
- R8: A writeback to the same warp in the same cycle as a decode is bypassed: the slot it frees sets no dependency bit in the new entry.
- R9: An issue and a decode of the same warp in the same cycle: the slot reserved by that issue takes part in the decode lookup.
- R10: Slots and dependency bits of a warp are affected only by decodes, issues and writebacks addressed to that warp. No dependency bit ever becomes set except by a decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decoded instruction is written into its warp's entry |
| dec_warp | input | 3 | Warp of the decoded instruction |
| dec_src_a | input | 7 | First source register |
| dec_src_b | input | 7 | Second source register |
| dec_wr_en | input | 1 | Decoded instruction writes a register |
| dec_dst | input | 7 | Destination register |
| iss_valid | input | 1 | Warp's buffered entry issues this cycle |
| iss_warp | input | 3 | Issuing warp |
| iss_slot | output | 3 | Slot reserved by the issuing instruction |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | 3 | Warp of the writeback |
| wb_slot | input | 3 | Slot released by the writeback |
| entry_valid | output | 8 | Per warp: buffered entry holds an instruction |
| ready | output | 8 | Per warp: entry may be issued |

## Verification
The checker covers four properties on every cycle. A writeback leaves its slot free and its dependency bit clear in the following cycle. A full pool blocks a register-writing entry. Ready never shows without a valid entry. Dependency bits outside a decode only ever drop. The bench's scenarios are needed for the rest. Only they can show that the right slots are flagged for read-after-write and write-after-write matches, and that the lowest free slot is chosen. They also show that same-cycle writeback and issue are forwarded into a decode, and that reset leaves the block idle. A bench reference model runs beside a long random run and covers the mixed traffic.

// File: rtl/warp_scoreboard.sv
module warp_scoreboard #(
  parameter int NUM_WARPS = 8,
  parameter int SLOTS     = 6,
  parameter int REG_W     = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dec_valid,
  input  logic [$clog2(NUM_WARPS)-1:0]  dec_warp,
  input  logic [REG_W-1:0]              dec_src_a,
  input  logic [REG_W-1:0]              dec_src_b,
  input  logic                          dec_wr_en,
  input  logic [REG_W-1:0]              dec_dst,
  input  logic                          iss_valid,
  input  logic [$clog2(NUM_WARPS)-1:0]  iss_warp,
  output logic [$clog2(SLOTS)-1:0]      iss_slot,
  input  logic                          wb_valid,
  input  logic [$clog2(NUM_WARPS)-1:0]  wb_warp,
  input  logic [$clog2(SLOTS)-1:0]      wb_slot,
  output logic [NUM_WARPS-1:0]          entry_valid,
  output logic [NUM_WARPS-1:0]          ready
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOTS-1:0] slot_v [NUM_WARPS];
  logic [REG_W-1:0] slot_r [NUM_WARPS][SLOTS];
  logic [NUM_WARPS-1:0] ent_v, ent_wr;
  logic [REG_W-1:0] ent_dst [NUM_WARPS];
  logic [SLOTS-1:0] ent_dep [NUM_WARPS];

  logic [SLOTS-1:0] lk_wb, lk_is, lk_v, dec_dep;
  logic [REG_W-1:0] lk_r [SLOTS];
  logic iss_reserve;

  logic [NUM_WARPS*SLOTS-1:0] busy_flat, dep_flat;

  always_comb begin
    iss_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (!slot_v[iss_warp][s]) iss_slot = SLOT_W'(s);
  end

  assign iss_reserve = iss_valid && ent_v[iss_warp] && ent_wr[iss_warp];

  for (genvar s = 0; s < SLOTS; s++) begin : g_lookup
    assign lk_wb[s] = wb_valid && (wb_warp == dec_warp) && (wb_slot == SLOT_W'(s));
    assign lk_is[s] = iss_reserve && (iss_warp == dec_warp) && (iss_slot == SLOT_W'(s));
    assign lk_v[s]  = lk_is[s] || (slot_v[dec_warp][s] && !lk_wb[s]);
    assign lk_r[s]  = lk_is[s] ? ent_dst[iss_warp] : slot_r[dec_warp][s];
    assign dec_dep[s] = lk_v[s] && ((lk_r[s] == dec_src_a) || (lk_r[s] == dec_src_b) ||
                                    (dec_wr_en && (lk_r[s] == dec_dst)));
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic hit_dec, hit_iss, hit_wb;
    logic [SLOTS-1:0] wb_clr, is_set;

    assign hit_dec = dec_valid && (dec_warp == w[$clog2(NUM_WARPS)-1:0]);
    assign hit_iss = iss_valid && (iss_warp == w[$clog2(NUM_WARPS)-1:0]);
    assign hit_wb  = wb_valid  && (wb_warp  == w[$clog2(NUM_WARPS)-1:0]);

    for (genvar s = 0; s < SLOTS; s++) begin : g_mask
      assign wb_clr[s] = hit_wb && (wb_slot == SLOT_W'(s));
      assign is_set[s] = hit_iss && iss_reserve && (iss_slot == SLOT_W'(s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[w]  <= '0;
        ent_v[w]   <= 1'b0;
        ent_wr[w]  <= 1'b0;
        ent_dep[w] <= '0;
      end else begin
        slot_v[w] <= (slot_v[w] & ~wb_clr) | is_set;
        if (hit_dec) begin
          ent_v[w]   <= 1'b1;
          ent_wr[w]  <= dec_wr_en;
          ent_dep[w] <= dec_dep;
        end else begin
          if (hit_iss) ent_v[w] <= 1'b0;
          ent_dep[w] <= ent_dep[w] & ~wb_clr;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (hit_dec) ent_dst[w] <= dec_dst;
      for (int s = 0; s < SLOTS; s++)
        if (is_set[s]) slot_r[w][s] <= ent_dst[w];
    end

    assign ready[w] = ent_v[w] && (ent_dep[w] == '0) && !(ent_wr[w] && (&slot_v[w]));
    assign busy_flat[w*SLOTS +: SLOTS] = slot_v[w];
    assign dep_flat[w*SLOTS +: SLOTS]  = ent_dep[w];
  end

  assign entry_valid = ent_v;
endmodule

// File: rtl/warp_scoreboard_chk.sv
module warp_scoreboard_chk #(
  parameter int NUM_WARPS = 8,
  parameter int SLOTS     = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          dec_valid,
  input logic [$clog2(NUM_WARPS)-1:0]  dec_warp,
  input logic                          wb_valid,
  input logic [$clog2(NUM_WARPS)-1:0]  wb_warp,
  input logic [$clog2(SLOTS)-1:0]      wb_slot,
  input logic [NUM_WARPS-1:0]          entry_valid,
  input logic [NUM_WARPS-1:0]          ready,
  input logic [NUM_WARPS-1:0]          ent_wr,
  input logic [NUM_WARPS*SLOTS-1:0]    busy_flat,
  input logic [NUM_WARPS*SLOTS-1:0]    dep_flat
);
  int wb_idx;
  assign wb_idx = int'(wb_warp) * SLOTS + int'(wb_slot);

  // R6
  wb_clears_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_slot < SLOTS) |=> !dep_flat[$past(wb_idx)]);

  // R6
  wb_frees_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_slot < SLOTS) |=> !busy_flat[$past(wb_idx)]);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
    // R2
    ready_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready[w] |-> entry_valid[w]);

    // R7
    full_pool_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_wr[w] && (&busy_flat[w*SLOTS +: SLOTS])) |-> !ready[w]);

    // R10
    dep_only_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_valid && dec_warp == w[$clog2(NUM_WARPS)-1:0]) |=>
      ((dep_flat[w*SLOTS +: SLOTS] & ~$past(dep_flat[w*SLOTS +: SLOTS])) == '0));
  end
endmodule

bind warp_scoreboard warp_scoreboard_chk #(.NUM_WARPS(NUM_WARPS), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_warp(dec_warp),
  .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_slot(wb_slot),
  .entry_valid(entry_valid), .ready(ready), .ent_wr(ent_wr),
  .busy_flat(busy_flat), .dep_flat(dep_flat)
);

// File: tb/test_warp_scoreboard.sv
module test_warp_scoreboard;
  localparam int NW = 8;
  localparam int NS = 6;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, dec_wr_en = 0, iss_valid = 0, wb_valid = 0;
  logic [2:0] dec_warp = 0, iss_warp = 0, wb_warp = 0, wb_slot = 0, iss_slot;
  logic [6:0] dec_src_a = 0, dec_src_b = 0, dec_dst = 0;
  logic [NW-1:0] entry_valid, ready;

  int checks = 0, fails = 0;
  bit finished = 0;

  bit       m_sv [NW][NS];
  bit [6:0] m_sr [NW][NS];
  bit       m_ev [NW];
  bit       m_ew [NW];
  bit [6:0] m_ed [NW];
  bit [NS-1:0] m_dep [NW];

  warp_scoreboard i_warp_scoreboard (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_warp(dec_warp),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_wr_en(dec_wr_en), .dec_dst(dec_dst),
    .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_slot(iss_slot),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_slot(wb_slot),
    .entry_valid(entry_valid), .ready(ready)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_full(int w);
    for (int s = 0; s < NS; s++) if (!m_sv[w][s]) return 0;
    return 1;
  endfunction

  function automatic bit m_ready(int w);
    return m_ev[w] && m_dep[w] == 0 && !(m_ew[w] && m_full(w));
  endfunction

  function automatic int m_free(int w);
    for (int s = 0; s < NS; s++) if (!m_sv[w][s]) return s;
    return 0;
  endfunction

  task automatic model_clear();
    for (int w = 0; w < NW; w++) begin
      m_ev[w] = 0; m_ew[w] = 0; m_dep[w] = 0; m_ed[w] = 0;
      for (int s = 0; s < NS; s++) begin m_sv[w][s] = 0; m_sr[w][s] = 0; end
    end
  endtask

  task automatic idle_inputs();
    dec_valid = 0; iss_valid = 0; wb_valid = 0; dec_wr_en = 0;
  endtask

  // Inputs are set after a falling edge; this call finishes one clock
  task automatic cycle(string tag);
    int dw, iw, ww, ws, isl;
    bit res;
    bit [NS-1:0] nd;
    dw = dec_warp; iw = iss_warp; ww = wb_warp; ws = wb_slot;
    res = iss_valid && m_ev[iw] && m_ew[iw];
    isl = m_free(iw);
    #1;
    if (res) chk(iss_slot == isl, "R5 iss_slot", iss_slot, isl);
    nd = 0;
    for (int s = 0; s < NS; s++) begin
      bit lv; bit [6:0] lr;
      lv = m_sv[dw][s]; lr = m_sr[dw][s];
      if (wb_valid && ww == dw && ws == s) lv = 0;
      if (res && iw == dw && isl == s) begin lv = 1; lr = m_ed[iw]; end
      nd[s] = lv && (lr == dec_src_a || lr == dec_src_b || (dec_wr_en && lr == dec_dst));
    end
    @(posedge clk);
    #1;
    if (wb_valid) m_sv[ww][ws] = 0;
    if (res) begin m_sv[iw][isl] = 1; m_sr[iw][isl] = m_ed[iw]; end
    if (iss_valid && !(dec_valid && dw == iw)) m_ev[iw] = 0;
    if (wb_valid && !(dec_valid && dw == ww)) m_dep[ww][ws] = 0;
    if (dec_valid) begin
      m_ev[dw] = 1; m_ew[dw] = dec_wr_en; m_ed[dw] = dec_dst; m_dep[dw] = nd;
    end
    @(negedge clk);
    idle_inputs();
    for (int w = 0; w < NW; w++) begin
      chk(ready[w] == m_ready(w), tag, ready[w], m_ready(w));
      chk(entry_valid[w] == m_ev[w], tag, entry_valid[w], m_ev[w]);
    end
  endtask

  task automatic set_dec(int w, int a, int b, bit wr, int d);
    dec_valid = 1; dec_warp = 3'(w); dec_src_a = 7'(a); dec_src_b = 7'(b);
    dec_wr_en = wr; dec_dst = 7'(d);
  endtask
  task automatic set_iss(int w); iss_valid = 1; iss_warp = 3'(w); endtask
  task automatic set_wb(int w, int s); wb_valid = 1; wb_warp = 3'(w); wb_slot = 3'(s); endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    model_clear();
    #1;
    // R1
    chk(ready == 0, "R1 ready in reset", ready, 0);
    chk(entry_valid == 0, "R1 entry_valid in reset", entry_valid, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready == 0, "R1 ready after reset", ready, 0);
    chk(entry_valid == 0, "R1 entry_valid after reset", entry_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    do_reset();

    set_dec(0, 1, 2, 1, 10); cycle("R2 clean decode");
    chk(ready[0] == 1, "R2 ready", ready[0], 1);
    set_iss(0); cycle("R5 issue");
    chk(entry_valid[0] == 0, "R5 entry dropped", entry_valid[0], 0);
    set_dec(0, 10, 3, 1, 11); cycle("R3 raw");
    chk(ready[0] == 0, "R3 raw hold", ready[0], 0);
    set_dec(1, 10, 10, 1, 12); cycle("R10 other warp");
    chk(ready[1] == 1, "R10 warp isolation", ready[1], 1);
    set_wb(0, 0); cycle("R6 release");
    chk(ready[0] == 1, "R6 ready after wb", ready[0], 1);
    set_iss(0); cycle("R5 reuse slot 0");
    set_dec(0, 1, 2, 1, 11); cycle("R4 waw");
    chk(ready[0] == 0, "R4 waw hold", ready[0], 0);
    set_wb(0, 0); cycle("R4 release");

    set_dec(2, 0, 0, 1, 20); cycle("R6 setup"); set_iss(2); cycle("R6 setup");
    set_dec(2, 0, 0, 1, 21); cycle("R6 setup"); set_iss(2); cycle("R6 setup");
    set_dec(2, 20, 21, 1, 22); cycle("R6 two deps");
    set_wb(2, 0); cycle("R6 first wb");
    chk(ready[2] == 0, "R6 still waiting", ready[2], 0);
    set_wb(2, 1); cycle("R6 second wb");
    chk(ready[2] == 1, "R6 all cleared", ready[2], 1);

    for (int i = 0; i < NS; i++) begin
      set_dec(3, 0, 0, 1, 30 + i); cycle("R7 fill"); set_iss(3); cycle("R7 fill");
    end
    set_dec(3, 1, 2, 1, 40); cycle("R7 full");
    chk(ready[3] == 0, "R7 full pool holds writer", ready[3], 0);
    set_dec(3, 1, 2, 0, 40); cycle("R7 no dst");
    chk(ready[3] == 1, "R7 non-writer passes", ready[3], 1);
    set_dec(3, 1, 2, 1, 41); cycle("R7 full again");
    set_wb(3, 3); cycle("R7 slot freed");
    chk(ready[3] == 1, "R7 ready after free", ready[3], 1);
    set_iss(3); cycle("R5 refill slot 3");

    set_dec(4, 0, 0, 1, 50); cycle("R8 setup"); set_iss(4); cycle("R8 setup");
    set_dec(4, 50, 1, 1, 51); set_wb(4, 0); cycle("R8 bypass");
    chk(ready[4] == 1, "R8 wb bypass", ready[4], 1);

    set_dec(5, 0, 0, 1, 60); cycle("R9 setup");
    set_iss(5); set_dec(5, 60, 1, 1, 61); cycle("R9 forward");
    chk(ready[5] == 0, "R9 issue forwarded", ready[5], 0);
    set_wb(5, 0); cycle("R9 release");
    chk(ready[5] == 1, "R9 ready after wb", ready[5], 1);

    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int w, rmax;
      rmax = (n < 3000) ? 7 : 127;
      if ($urandom_range(0, 2) != 0) begin
        w = $urandom_range(0, NW - 1);
        if (m_ready(w)) set_iss(w);
      end
      if ($urandom_range(0, 2) != 0) begin
        w = $urandom_range(0, NW - 1);
        if (!m_ev[w] || (iss_valid && iss_warp == w))
          set_dec(w, $urandom_range(0, rmax), $urandom_range(0, rmax),
                  $urandom_range(0, 4) != 0, $urandom_range(0, rmax));
      end
      if ($urandom_range(0, 2) != 0) begin
        int s;
        w = $urandom_range(0, NW - 1);
        s = $urandom_range(0, NS - 1);
        if (m_sv[w][s]) set_wb(w, s);
      end
      cycle("R6 random traffic");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule